// File: doc/BRIEF.md
# Barrel Shifter with Carry-Out

This block shifts or rotates a 32-bit operand in a single combinational pass and reports the bit that leaves the word, which a processor uses as its shifter carry. Four kinds of operation are supported: logical left, logical right, arithmetic right and rotate right. The shift distance comes either from a 5-bit immediate field or from the low byte of a count register.

A register-supplied distance may be anywhere from 0 to 255. The block therefore has separate rules for a distance of zero, for exactly the word width, and for anything beyond it. A carry-valid output tells the flag logic whether to load the new carry or keep the previous C flag. When it is low, the carry output simply repeats the incoming flag, so downstream logic can always take `carry_o` as is.

Top module: `barrel_shift_unit`

## Requirements
- R1: `kind_i` encodes 00 = logical left, 01 = logical right, 10 = arithmetic right, 11 = rotate right. `use_reg_i` = 1 takes the distance n from `reg_amt_i` (0..255); `use_reg_i` = 0 takes it from `imm_amt_i` (0..31), and the other source has no effect.
- R2: For n = 0 from either source, `result_o` equals `opnd_i`, `carry_valid_o` is 0 and `carry_o` equals `c_flag_i`.
- R3: Logical left with 1 <= n <= 31 gives `opnd_i << n` and carry = `opnd_i[32-n]`.
- R4: Logical right and arithmetic right with 1 <= n <= 31 give the zero-filled or sign-filled right shift, with carry = `opnd_i[n-1]`.
- R5: A logical shift with n = 32 gives zero. The carry is `opnd_i[0]` for a left shift and `opnd_i[31]` for a right shift.
- R6: A logical left or right shift with 33 <= n <= 255 gives zero with carry 0.
- R7: An arithmetic right shift with n >= 32 sets every result bit to `opnd_i[31]`, and the carry is also `opnd_i[31]`.
- R8: Rotate right uses r = n mod 32. If r != 0, the result is the operand rotated by r and the carry is `opnd_i[r-1]`. If r = 0 and n != 0, the result is unchanged and the carry is `opnd_i[31]`.
- R9: `carry_valid_o` is 1 for every nonzero n, whatever the kind of operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opnd_i | input | 32 | Operand to shift or rotate |
| imm_amt_i | input | 5 | Immediate shift distance |
| reg_amt_i | input | 8 | Low byte of the count register |
| use_reg_i | input | 1 | 1 selects the register distance, 0 the immediate |
| kind_i | input | 2 | Shift kind (see R1) |
| c_flag_i | input | 1 | Current C flag |
| result_o | output | 32 | Shifted or rotated value |
| carry_o | output | 1 | Shifter carry, or `c_flag_i` when not valid |
| carry_valid_o | output | 1 | 1 when the C flag should take `carry_o` |

## Verification
The bench targets the distance boundaries 0, 1, 31, 32, 33 and 255 for every kind of shift, plus rotate distances that are nonzero multiples of 32. Each boundary catches a typical defect:
- A design that masks register distances to five bits returns the operand where zero is required for distances of 32 and above.
- A design that uses a single carry rule for all large distances gets the carry wrong at exactly 32.
- A rotate that treats a distance of 64 as zero leaves the carry invalid when it should be `opnd_i[31]`.
- Zero distances are checked for an unchanged C flag, which exposes any design that raises carry-valid unconditionally.

Vectors with differing immediate and register distances show that the source select does not leak.

// File: rtl/shf_pkg.sv
package shf_pkg;

    typedef enum logic [1:0] {
        SHK_LSL = 2'b00,
        SHK_LSR = 2'b01,
        SHK_ASR = 2'b10,
        SHK_ROR = 2'b11
    } shift_kind_e;

endpackage

// File: rtl/shf_amount_decode.sv
module shf_amount_decode #(
    parameter int WIDTH    = 32,
    parameter int AMT_BITS = 8,
    parameter int IMM_BITS = 5,
    parameter int SH_BITS  = 5
) (
    input  logic                use_reg_i,
    input  logic [IMM_BITS-1:0] imm_amt_i,
    input  logic [AMT_BITS-1:0] reg_amt_i,
    output logic [SH_BITS-1:0]  low_o,
    output logic                is_zero_o,
    output logic                in_range_o,
    output logic                is_exact_o,
    output logic                is_over_o
);
    logic [AMT_BITS-1:0] amt_d;

    always_comb begin
        amt_d      = use_reg_i ? reg_amt_i : AMT_BITS'(imm_amt_i);
        low_o      = amt_d[SH_BITS-1:0];
        is_zero_o  = (amt_d == '0);
        is_exact_o = (amt_d == AMT_BITS'(WIDTH));
        is_over_o  = (amt_d >  AMT_BITS'(WIDTH));
        in_range_o = !is_zero_o && (amt_d < AMT_BITS'(WIDTH));
    end
endmodule

// File: rtl/shf_right_stages.sv
module shf_right_stages #(
    parameter int WIDTH   = 32,
    parameter int SH_BITS = 5
) (
    input  logic [WIDTH-1:0]   data_i,
    input  logic               fill_i,
    input  logic [SH_BITS-1:0] amt_i,
    output logic [WIDTH-1:0]   shr_o,
    output logic               shout_o
);
    // One guard bit below the word catches the last bit shifted out.
    logic [WIDTH:0] ext_d;

    always_comb begin
        ext_d = {data_i, 1'b0};
        for (int k = 0; k < SH_BITS; k++) begin
            if (amt_i[k]) begin
                if (fill_i) ext_d = ~((~ext_d) >> (1 << k));
                else        ext_d = ext_d >> (1 << k);
            end
        end
        shr_o   = ext_d[WIDTH:1];
        shout_o = ext_d[0];
    end
endmodule

// File: rtl/shf_rotate.sv
module shf_rotate #(
    parameter int WIDTH   = 32,
    parameter int SH_BITS = 5
) (
    input  logic [WIDTH-1:0]   data_i,
    input  logic [SH_BITS-1:0] amt_i,
    output logic [WIDTH-1:0]   rot_o
);
    logic [WIDTH-1:0] rot_d;

    always_comb begin
        rot_d = data_i;
        for (int k = 0; k < SH_BITS; k++) begin
            if (amt_i[k]) rot_d = (rot_d >> (1 << k)) | (rot_d << (WIDTH - (1 << k)));
        end
        rot_o = rot_d;
    end
endmodule

// File: rtl/barrel_shift_unit.sv
module barrel_shift_unit
    import shf_pkg::*;
#(
    parameter int WIDTH    = 32,
    parameter int AMT_BITS = 8
) (
    input  logic [WIDTH-1:0]          opnd_i,
    input  logic [$clog2(WIDTH)-1:0]  imm_amt_i,
    input  logic [AMT_BITS-1:0]       reg_amt_i,
    input  logic                      use_reg_i,
    input  logic [1:0]                kind_i,
    input  logic                      c_flag_i,
    output logic [WIDTH-1:0]          result_o,
    output logic                      carry_o,
    output logic                      carry_valid_o
);
    localparam int SH_BITS  = $clog2(WIDTH);
    localparam int IMM_BITS = SH_BITS;

    typedef struct packed {
        logic [WIDTH-1:0] result;
        logic             carry;
        logic             valid;
    } shf_out_t;

    shf_out_t         out_d;
    shift_kind_e      kind_d;
    logic [SH_BITS-1:0] low_q;
    logic             zero_q, in_range_q, exact_q, over_q;
    logic [WIDTH-1:0] opnd_rev_d, left_rev_d, left_val_d;
    logic [WIDTH-1:0] right_val_d, rot_val_d;
    logic             left_out_d, right_out_d, right_fill_d;

    assign kind_d       = shift_kind_e'(kind_i);
    assign right_fill_d = (kind_d == SHK_ASR) && opnd_i[WIDTH-1];

    // A left shift is a right shift of the bit-reversed word.
    for (genvar i = 0; i < WIDTH; i++) begin : g_rev
        assign opnd_rev_d[i] = opnd_i[WIDTH-1-i];
        assign left_val_d[i] = left_rev_d[WIDTH-1-i];
    end

    shf_amount_decode #(
        .WIDTH(WIDTH), .AMT_BITS(AMT_BITS), .IMM_BITS(IMM_BITS), .SH_BITS(SH_BITS)
    ) u_amt (
        .use_reg_i (use_reg_i),
        .imm_amt_i (imm_amt_i),
        .reg_amt_i (reg_amt_i),
        .low_o     (low_q),
        .is_zero_o (zero_q),
        .in_range_o(in_range_q),
        .is_exact_o(exact_q),
        .is_over_o (over_q)
    );

    shf_right_stages #(.WIDTH(WIDTH), .SH_BITS(SH_BITS)) u_right (
        .data_i (opnd_i),
        .fill_i (right_fill_d),
        .amt_i  (low_q),
        .shr_o  (right_val_d),
        .shout_o(right_out_d)
    );

    shf_right_stages #(.WIDTH(WIDTH), .SH_BITS(SH_BITS)) u_left (
        .data_i (opnd_rev_d),
        .fill_i (1'b0),
        .amt_i  (low_q),
        .shr_o  (left_rev_d),
        .shout_o(left_out_d)
    );

    shf_rotate #(.WIDTH(WIDTH), .SH_BITS(SH_BITS)) u_rot (
        .data_i(opnd_i),
        .amt_i (low_q),
        .rot_o (rot_val_d)
    );

    always_comb begin
        out_d.result = opnd_i;
        out_d.carry  = c_flag_i;
        out_d.valid  = 1'b0;
        if (!zero_q) begin
            out_d.valid = 1'b1;
            unique case (kind_d)
                SHK_LSL: begin
                    if (in_range_q) begin
                        out_d.result = left_val_d;
                        out_d.carry  = left_out_d;
                    end else begin
                        out_d.result = '0;
                        out_d.carry  = exact_q ? opnd_i[0] : 1'b0;
                    end
                end
                SHK_LSR: begin
                    if (in_range_q) begin
                        out_d.result = right_val_d;
                        out_d.carry  = right_out_d;
                    end else begin
                        out_d.result = '0;
                        out_d.carry  = exact_q ? opnd_i[WIDTH-1] : 1'b0;
                    end
                end
                SHK_ASR: begin
                    if (in_range_q) begin
                        out_d.result = right_val_d;
                        out_d.carry  = right_out_d;
                    end else begin
                        out_d.result = {WIDTH{opnd_i[WIDTH-1]}};
                        out_d.carry  = opnd_i[WIDTH-1];
                    end
                end
                default: begin
                    // Rotation by a multiple of the width keeps the value.
                    out_d.result = rot_val_d;
                    out_d.carry  = rot_val_d[WIDTH-1];
                end
            endcase
        end
    end

    assign result_o      = out_d.result;
    assign carry_o       = out_d.carry;
    assign carry_valid_o = out_d.valid;

    // Decode flags beyond in-range are folded into the carry choice above.
    logic unused_over_d;
    assign unused_over_d = over_q;
endmodule

// File: rtl/shf_checker.sv
module shf_checker #(
    parameter int WIDTH    = 32,
    parameter int AMT_BITS = 8
) (
    input logic [WIDTH-1:0]         opnd_i,
    input logic [$clog2(WIDTH)-1:0] imm_amt_i,
    input logic [AMT_BITS-1:0]      reg_amt_i,
    input logic                     use_reg_i,
    input logic [1:0]               kind_i,
    input logic                     c_flag_i,
    input logic [WIDTH-1:0]         result_o,
    input logic                     carry_o,
    input logic                     carry_valid_o
);
    int unsigned n_d;

    always_comb begin
        n_d = use_reg_i ? int'(reg_amt_i) : int'(imm_amt_i);

        if (n_d == 0) begin
            assert_zero_keeps_R2: assert (result_o == opnd_i && !carry_valid_o && carry_o == c_flag_i)
                else $error("zero distance altered value or flag");
        end else begin
            assert_valid_nonzero_R9: assert (carry_valid_o)
                else $error("carry not valid for nonzero distance");
        end

        if (kind_i == 2'b10 && n_d >= WIDTH) begin
            assert_asr_sign_R7: assert (result_o == {WIDTH{opnd_i[WIDTH-1]}} && carry_o == opnd_i[WIDTH-1])
                else $error("arithmetic shift past width not sign filled");
        end

        if (kind_i[1] == 1'b0 && n_d > WIDTH) begin
            assert_logic_over_R6: assert (result_o == '0 && !carry_o)
                else $error("logical shift past width not cleared");
        end

        if (kind_i == 2'b11 && n_d != 0) begin
            assert_rot_bits_R8: assert ($countones(result_o) == $countones(opnd_i) && carry_o == result_o[WIDTH-1])
                else $error("rotate lost bits or carry mismatch");
        end
    end
endmodule

bind barrel_shift_unit shf_checker #(.WIDTH(WIDTH), .AMT_BITS(AMT_BITS)) u_shf_chk (
    .opnd_i       (opnd_i),
    .imm_amt_i    (imm_amt_i),
    .reg_amt_i    (reg_amt_i),
    .use_reg_i    (use_reg_i),
    .kind_i       (kind_i),
    .c_flag_i     (c_flag_i),
    .result_o     (result_o),
    .carry_o      (carry_o),
    .carry_valid_o(carry_valid_o)
);

// File: tb/tb_barrel_shift_unit.sv
`timescale 1ns/1ps
module tb_barrel_shift_unit;

    logic        clk = 1'b0;
    logic [31:0] opnd_i = '0;
    logic [4:0]  imm_amt_i = '0;
    logic [7:0]  reg_amt_i = '0;
    logic        use_reg_i = 1'b0;
    logic [1:0]  kind_i = '0;
    logic        c_flag_i = 1'b0;
    logic [31:0] result_o;
    logic        carry_o, carry_valid_o;

    always #2.5 clk = ~clk;

    barrel_shift_unit dut (
        .opnd_i(opnd_i), .imm_amt_i(imm_amt_i), .reg_amt_i(reg_amt_i),
        .use_reg_i(use_reg_i), .kind_i(kind_i), .c_flag_i(c_flag_i),
        .result_o(result_o), .carry_o(carry_o), .carry_valid_o(carry_valid_o)
    );

    typedef struct {
        string       tag;
        logic [31:0] res;
        logic        c;
        logic        v;
    } exp_t;

    exp_t exp_q[$];
    int   n_checks = 0;
    int   n_fail   = 0;
    bit   done     = 0;

    // Reference model written from the requirements.
    function automatic exp_t model(input logic [31:0] x, input int n,
                                   input logic [1:0] k, input logic cin);
        exp_t e;
        int r;
        e.tag = "";
        e.res = x; e.c = cin; e.v = 1'b0;
        if (n == 0) return e;
        e.v = 1'b1;
        case (k)
            2'b00: if (n < 32) begin e.res = x << n; e.c = x[32-n]; end
                   else begin e.res = '0; e.c = (n == 32) ? x[0] : 1'b0; end
            2'b01: if (n < 32) begin e.res = x >> n; e.c = x[n-1]; end
                   else begin e.res = '0; e.c = (n == 32) ? x[31] : 1'b0; end
            2'b10: if (n < 32) begin e.res = 32'($signed(x) >>> n); e.c = x[n-1]; end
                   else begin e.res = {32{x[31]}}; e.c = x[31]; end
            default: begin
                r = n % 32;
                if (r != 0) begin e.res = (x >> r) | (x << (32 - r)); e.c = x[r-1]; end
                else begin e.res = x; e.c = x[31]; end
            end
        endcase
        return e;
    endfunction

    function automatic string classify(input int n, input logic [1:0] k);
        if (n == 0)               return "R2";
        if (k == 2'b11)           return "R8";
        if (n < 32)               return (k == 2'b00) ? "R3" : "R4";
        if (k == 2'b10)           return "R7";
        if (n == 32)              return "R5";
        return "R6";
    endfunction

    task automatic drive(input logic [31:0] x, input logic [1:0] k, input logic sel,
                         input logic [4:0] imm, input logic [7:0] rg, input logic cin,
                         input string tag);
        exp_t e;
        int n;
        @(posedge clk);
        opnd_i = x; kind_i = k; use_reg_i = sel;
        imm_amt_i = imm; reg_amt_i = rg; c_flag_i = cin;
        n = sel ? int'(rg) : int'(imm);
        e = model(x, n, k, cin);
        e.tag = (tag == "") ? classify(n, k) : tag;
        exp_q.push_back(e);
    endtask

    // Monitor: compare away from the driving edge.
    always @(negedge clk) begin
        if (exp_q.size() > 0) begin
            exp_t e;
            e = exp_q.pop_front();
            n_checks++;
            if (result_o !== e.res || carry_o !== e.c || carry_valid_o !== e.v) begin
                n_fail++;
                $display("FAIL %s: got res=%h c=%b v=%b, expected res=%h c=%b v=%b",
                         e.tag, result_o, carry_o, carry_valid_o, e.res, e.c, e.v);
            end
        end
    end

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog: got timeout, expected completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin : stim
        logic [31:0] pats [4];
        pats[0] = 32'h8000_0001; pats[1] = 32'h7FFF_FFFE;
        pats[2] = 32'hA5C3_0F96; pats[3] = 32'hFFFF_FFFF;

        // Idle state with everything at zero.
        drive(32'h0, 2'b00, 1'b0, 5'd0, 8'd0, 1'b0, "R2");
        // Zero distance keeps value and flag, both sources.
        drive(32'h1234_5678, 2'b01, 1'b1, 5'd7, 8'd0, 1'b1, "R2");
        drive(32'h1234_5678, 2'b11, 1'b0, 5'd0, 8'd9, 1'b1, "R2");
        drive(32'hDEAD_BEEF, 2'b10, 1'b1, 5'd3, 8'd0, 1'b0, "R2");
        // Source select: the unselected distance must not matter.
        drive(32'h0000_00F0, 2'b01, 1'b0, 5'd4, 8'd200, 1'b0, "R1");
        drive(32'h0000_00F0, 2'b01, 1'b1, 5'd31, 8'd4, 1'b0, "R1");
        drive(32'h8000_0000, 2'b10, 1'b0, 5'd1, 8'd0, 1'b0, "R1");
        drive(32'h8000_0000, 2'b00, 1'b0, 5'd1, 8'd0, 1'b0, "R1");
        // Boundaries for every kind and pattern.
        for (int p = 0; p < 4; p++) begin
            for (int k = 0; k < 4; k++) begin
                drive(pats[p], 2'(k), 1'b1, 5'd0, 8'd1,   1'b0, "");
                drive(pats[p], 2'(k), 1'b1, 5'd0, 8'd31,  1'b1, "");
                drive(pats[p], 2'(k), 1'b1, 5'd0, 8'd32,  1'b1, "");
                drive(pats[p], 2'(k), 1'b1, 5'd0, 8'd33,  1'b1, "");
                drive(pats[p], 2'(k), 1'b1, 5'd0, 8'd64,  1'b1, "");
                drive(pats[p], 2'(k), 1'b1, 5'd0, 8'd255, 1'b1, "");
                drive(pats[p], 2'(k), 1'b0, 5'd16, 8'd0,  1'b0, "");
            end
        end
        // Carry valid for nonzero distances with the flag low.
        for (int k = 0; k < 4; k++)
            drive(32'h0F0F_0F0F, 2'(k), 1'b1, 5'd0, 8'd96, 1'b0, "R9");
        // Mixed vectors.
        for (int i = 0; i < 600; i++) begin
            logic [7:0] rg;
            rg = 8'($urandom);
            if (i % 3 == 0) rg = 8'($urandom_range(0, 40));
            drive($urandom, 2'($urandom), 1'($urandom), 5'($urandom), rg, 1'($urandom), "");
        end
        repeat (3) @(posedge clk);
        done = 1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule